// File: doc/BRIEF.md
# Board Control Register Bank

This block is a small bank of 32-bit control and status words for board-level housekeeping. A processor reaches it through a plain word bus: a byte offset, a write enable and 32-bit write data. Read data is returned in the same cycle from the current offset. Behind the bus the bank does several jobs. It reports a build date fixed by parameters and mirrors four configuration switches. It drives a status LED and a set of write-protect lines. It holds individual resets for four peripherals, and it gates six level interrupt sources through an enable mask onto one request line. It also overrides the top nibble of a bridge address.

A write of one exact magic word to the software-reset offset starts a board-wide reset pulse. The pulse lasts a fixed number of cycles. While it is active, every writable word goes back to its power-on value, so write protection is restored.

Top module: `board_ctrl_regs`

## Requirements
- R1: After rstN is released, the bank holds its defaults: ledOn=0, write-protect word 0xFF (flashWp=1), periphRst=0, interrupt enable word 0, bridge control bit 1, and boardRst=0.
- R2: A read of offset 0x00 returns the build date: BCD month in bits 31:24, BCD day in bits 23:16 and BCD year in bits 15:0, all taken from parameters. Writes to it are ignored.
- R3: A read of offset 0x04 returns switchIn in bits 3:0, where 1 means on, and zero above. Bits 1:0 carry the boot source: 0 flash, 1 16-bit EPROM, 2 8-bit PROM, 3 asynchronous SRAM. Writes to it are ignored.
- R4: Bit 0 of offset 0x08 is written and read back, and it drives ledOn (1 = lit). Other bit positions read as zero.
- R5: Offset 0x0C holds eight write-protect bits. All eight read back as written, and bit 0 drives flashWp (1 = protected).
- R6: Writing the full word 0x0000DEAD to offset 0x10 raises boardRst in the cycle after the write. boardRst then stays high for exactly 16 cycles. Any other value written there, including one with matching low 16 bits and nonzero upper bits, has no effect.
- R7: A software reset returns every writable word to its R1 default. Bus writes are ignored while boardRst is high.
- R8: Offset 0x14 holds four reset bits that drive periphRst: bit 0 display, bit 1 Ethernet, bit 2 dual UART, bit 3 PCI bridge. A 1 asserts the reset.
- R9: Offset 0x1C returns the interrupt sources in bits 7:2 (irqSrc[0] in bit 2), sampled one clock after the inputs change. Writes to it are ignored.
- R10: irqOut is high exactly when some bit 7:2 of the sampled sources is set and the matching bit of the enable word at offset 0x18 is also set. The enable word keeps bits 7:2 only.
- R11: While bit 0 of offset 0x20 is 1, bridgeAddrOut equals bridgeAddrIn with bits 31:28 replaced by 4'b0001. While it is 0, bridgeAddrOut equals bridgeAddrIn.
- R12: Reads of unmapped offsets, of offsets that are not word aligned and of offset 0x10 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous power-on reset, active low |
| busAddr | input | 8 | byte offset of the access |
| busWe | input | 1 | write enable |
| busWdata | input | 32 | write data |
| busRdata | output | 32 | read data for busAddr, same cycle |
| switchIn | input | 4 | configuration switches |
| irqSrc | input | 6 | level interrupt sources for status bits 7:2 |
| bridgeAddrIn | input | 32 | bridge address before override |
| ledOn | output | 1 | status LED drive |
| flashWp | output | 1 | flash write protect |
| periphRst | output | 4 | per-peripheral resets |
| irqOut | output | 1 | combined interrupt request |
| bridgeAddrOut | output | 32 | bridge address after override |
| boardRst | output | 1 | software reset pulse |

## Verification
The properties assume that busAddr, busWe and busWdata change only between clock edges and are stable at each rising edge. They also assume irqSrc is a level input and is not a pulse shorter than a cycle. The bench drives every input on the falling edge and holds it over the next rising edge. It samples outputs just after a falling edge, where the registered effect of the previous rising edge has settled. A write's result is therefore read back one cycle after it was issued.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int DATA_W  = 32;
  localparam int WP_W    = 8;
  localparam int PRST_W  = 4;
  localparam int SW_W    = 4;
  localparam int IRQ_LO  = 2;
  localparam int IRQ_N   = 6;

  // byte offsets of the words
  localparam int OFS_DATE = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_LED  = 'h08;
  localparam int OFS_WP   = 'h0C;
  localparam int OFS_SWR  = 'h10;
  localparam int OFS_PRST = 'h14;
  localparam int OFS_MASK = 'h18;
  localparam int OFS_PEND = 'h1C;
  localparam int OFS_CFG  = 'h20;

  typedef enum logic [3:0] {
    SEL_DATE, SEL_STAT, SEL_LED, SEL_WP, SEL_SWR,
    SEL_PRST, SEL_MASK, SEL_PEND, SEL_CFG, SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic wrLed;
    logic wrWp;
    logic wrPrst;
    logic wrMask;
    logic wrCfg;
    logic clrAll;
  } strobes_t;
endpackage

// File: rtl/bcr_ctrl.sv
module bcr_ctrl
  import bcr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PULSE_LEN = 16,
  parameter logic [DATA_W-1:0] MAGIC = 32'h0000_DEAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output rdSel_e            rdSel,
  output strobes_t          strobes,
  output logic              boardRst
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] pulseCnt;
  logic             busy;
  logic             wrOk;
  logic             magicHit;

  // offset decode; misaligned offsets fall through to none
  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFS_DATE): rdSel = SEL_DATE;
      ADDR_W'(OFS_STAT): rdSel = SEL_STAT;
      ADDR_W'(OFS_LED):  rdSel = SEL_LED;
      ADDR_W'(OFS_WP):   rdSel = SEL_WP;
      ADDR_W'(OFS_SWR):  rdSel = SEL_SWR;
      ADDR_W'(OFS_PRST): rdSel = SEL_PRST;
      ADDR_W'(OFS_MASK): rdSel = SEL_MASK;
      ADDR_W'(OFS_PEND): rdSel = SEL_PEND;
      ADDR_W'(OFS_CFG):  rdSel = SEL_CFG;
      default:           rdSel = SEL_NONE;
    endcase
  end

  assign busy     = (pulseCnt != '0);
  assign wrOk     = busWe && !busy;
  assign magicHit = wrOk && (rdSel == SEL_SWR) && (busWdata == MAGIC);

  always_comb begin
    strobes        = '0;
    strobes.wrLed  = wrOk && (rdSel == SEL_LED);
    strobes.wrWp   = wrOk && (rdSel == SEL_WP);
    strobes.wrPrst = wrOk && (rdSel == SEL_PRST);
    strobes.wrMask = wrOk && (rdSel == SEL_MASK);
    strobes.wrCfg  = wrOk && (rdSel == SEL_CFG);
    strobes.clrAll = magicHit || busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (magicHit) begin
      pulseCnt <= CNT_W'(PULSE_LEN);
    end else if (busy) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign boardRst = busy;
endmodule

// File: rtl/bcr_datapath.sv
module bcr_datapath
  import bcr_pkg::*;
#(
  parameter logic [7:0]  DATE_MONTH = 8'h06,
  parameter logic [7:0]  DATE_DAY   = 8'h15,
  parameter logic [15:0] DATE_YEAR  = 16'h2024
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  rdSel_e            rdSel,
  input  logic [WP_W-1:0]   wrByte,
  input  logic [SW_W-1:0]   switchIn,
  input  logic [IRQ_N-1:0]  irqSrc,
  input  logic [DATA_W-1:0] bridgeAddrIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              ledOn,
  output logic              flashWp,
  output logic [PRST_W-1:0] periphRst,
  output logic              irqOut,
  output logic [DATA_W-1:0] bridgeAddrOut
);
  localparam int IRQ_HI = IRQ_LO + IRQ_N - 1;
  localparam logic [WP_W-1:0] WP_DEF = '1;

  logic              ledReg;
  logic [WP_W-1:0]   wpReg;
  logic [PRST_W-1:0] prstReg;
  logic [IRQ_N-1:0]  maskReg;
  logic [IRQ_N-1:0]  pendReg;
  logic              cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledReg  <= 1'b0;
      wpReg   <= WP_DEF;
      prstReg <= '0;
      maskReg <= '0;
      cfgReg  <= 1'b1;
    end else if (strobes.clrAll) begin
      ledReg  <= 1'b0;
      wpReg   <= WP_DEF;
      prstReg <= '0;
      maskReg <= '0;
      cfgReg  <= 1'b1;
    end else begin
      if (strobes.wrLed)  ledReg  <= wrByte[0];
      if (strobes.wrWp)   wpReg   <= wrByte;
      if (strobes.wrPrst) prstReg <= wrByte[PRST_W-1:0];
      if (strobes.wrMask) maskReg <= wrByte[IRQ_HI:IRQ_LO];
      if (strobes.wrCfg)  cfgReg  <= wrByte[0];
    end
  end

  // level sources sampled once per clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendReg <= '0;
    else       pendReg <= irqSrc;
  end

  always_comb begin
    busRdata = '0;
    unique case (rdSel)
      SEL_DATE: busRdata = {DATE_MONTH, DATE_DAY, DATE_YEAR};
      SEL_STAT: busRdata[SW_W-1:0] = switchIn;
      SEL_LED:  busRdata[0] = ledReg;
      SEL_WP:   busRdata[WP_W-1:0] = wpReg;
      SEL_PRST: busRdata[PRST_W-1:0] = prstReg;
      SEL_MASK: busRdata[IRQ_HI:IRQ_LO] = maskReg;
      SEL_PEND: busRdata[IRQ_HI:IRQ_LO] = pendReg;
      SEL_CFG:  busRdata[0] = cfgReg;
      default:  busRdata = '0;
    endcase
  end

  assign ledOn     = ledReg;
  assign flashWp   = wpReg[0];
  assign periphRst = prstReg;
  assign irqOut    = |(pendReg & maskReg);
  assign bridgeAddrOut = cfgReg ? {4'b0001, bridgeAddrIn[DATA_W-5:0]} : bridgeAddrIn;
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import bcr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PULSE_LEN = 16,
  parameter logic [7:0]  DATE_MONTH = 8'h06,
  parameter logic [7:0]  DATE_DAY   = 8'h15,
  parameter logic [15:0] DATE_YEAR  = 16'h2024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [3:0]        switchIn,
  input  logic [5:0]        irqSrc,
  input  logic [31:0]       bridgeAddrIn,
  output logic              ledOn,
  output logic              flashWp,
  output logic [3:0]        periphRst,
  output logic              irqOut,
  output logic [31:0]       bridgeAddrOut,
  output logic              boardRst
);
  strobes_t strobes;
  rdSel_e   rdSel;

  bcr_ctrl #(
    .ADDR_W(ADDR_W),
    .PULSE_LEN(PULSE_LEN)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .busAddr(busAddr),
    .busWe(busWe),
    .busWdata(busWdata),
    .rdSel(rdSel),
    .strobes(strobes),
    .boardRst(boardRst)
  );

  bcr_datapath #(
    .DATE_MONTH(DATE_MONTH),
    .DATE_DAY(DATE_DAY),
    .DATE_YEAR(DATE_YEAR)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .rdSel(rdSel),
    .wrByte(busWdata[WP_W-1:0]),
    .switchIn(switchIn),
    .irqSrc(irqSrc),
    .bridgeAddrIn(bridgeAddrIn),
    .busRdata(busRdata),
    .ledOn(ledOn),
    .flashWp(flashWp),
    .periphRst(periphRst),
    .irqOut(irqOut),
    .bridgeAddrOut(bridgeAddrOut)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int ADDR_W    = 8,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [3:0]        switchIn,
  input logic              ledOn,
  input logic              flashWp,
  input logic [3:0]        periphRst,
  input logic              irqOut,
  input logic [31:0]       bridgeAddrOut,
  input logic              boardRst
);
  logic [15:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         hiCnt <= '0;
    else if (boardRst) hiCnt <= hiCnt + 16'd1;
    else               hiCnt <= '0;
  end

  // R6: pulse only after the exact magic word at the reset offset
  p_magic_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(boardRst) |-> $past(busWe && busAddr == ADDR_W'('h10) && busWdata == 32'h0000_DEAD));

  // R6: pulse length measured by a counter
  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!boardRst && $past(boardRst)) |-> hiCnt == 16'(PULSE_LEN));

  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    hiCnt <= 16'(PULSE_LEN));

  // R7: during the pulse the defaults are in force
  p_wp_safe_r7: assert property (@(posedge clk) disable iff (!rstN)
    boardRst |-> (flashWp && !ledOn && periphRst == 4'h0));

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    boardRst |-> !irqOut);

  p_bridge_default_r11: assert property (@(posedge clk) disable iff (!rstN)
    boardRst |-> bridgeAddrOut[31:28] == 4'b0001);

  // R3: status read mirrors switches
  p_status_mirror_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'('h04)) |-> busRdata == {28'h0, switchIn});

  // R12: software reset offset reads zero
  p_swr_reads_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'('h10)) |-> busRdata == 32'h0);
endmodule

bind board_ctrl_regs bcr_checker #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .busRdata(busRdata), .switchIn(switchIn), .ledOn(ledOn), .flashWp(flashWp),
  .periphRst(periphRst), .irqOut(irqOut), .bridgeAddrOut(bridgeAddrOut),
  .boardRst(boardRst)
);

// File: tb/board_ctrl_regs_tb.sv
`timescale 1ns/1ps
module board_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  switchIn = 4'h0;
  logic [5:0]  irqSrc = '0;
  logic [31:0] bridgeAddrIn = 32'hABCD_1234;
  logic        ledOn, flashWp, irqOut, boardRst;
  logic [3:0]  periphRst;
  logic [31:0] bridgeAddrOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  board_ctrl_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .switchIn(switchIn), .irqSrc(irqSrc),
    .bridgeAddrIn(bridgeAddrIn), .ledOn(ledOn), .flashWp(flashWp),
    .periphRst(periphRst), .irqOut(irqOut), .bridgeAddrOut(bridgeAddrOut),
    .boardRst(boardRst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 ledOn", 32'(ledOn), 0);
    chk("R1 flashWp", 32'(flashWp), 1);
    chk("R1 periphRst", 32'(periphRst), 0);
    chk("R1 boardRst", 32'(boardRst), 0);
    rd(8'h0C, v); chk("R1 wp word", v, 32'hFF);
    rd(8'h18, v); chk("R1 mask word", v, 0);
    rd(8'h20, v); chk("R1 cfg word", v, 1);
  endtask

  task automatic t_date();
    logic [31:0] v;
    rd(8'h00, v); chk("R2 date", v, 32'h0615_2024);
    wr(8'h00, 32'h1111_1111);
    rd(8'h00, v); chk("R2 date after write", v, 32'h0615_2024);
  endtask

  task automatic t_status();
    logic [31:0] v;
    for (int i = 0; i < 16; i += 5) begin
      switchIn = 4'(i);
      rd(8'h04, v); chk("R3 switches", v, 32'(i));
    end
    switchIn = 4'b0110;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R3 boot select 2 after write", v, 32'h6);
  endtask

  task automatic t_led();
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R4 ledOn on", 32'(ledOn), 1);
    rd(8'h08, v); chk("R4 led readback", v, 1);
    wr(8'h08, 32'h0000_0002);
    chk("R4 ledOn off", 32'(ledOn), 0);
  endtask

  task automatic t_wp();
    logic [31:0] v;
    wr(8'h0C, 32'hFFFF_FF5A);
    rd(8'h0C, v); chk("R5 wp readback", v, 32'h5A);
    chk("R5 flashWp clear", 32'(flashWp), 0);
    wr(8'h0C, 32'h0000_0081);
    chk("R5 flashWp set", 32'(flashWp), 1);
  endtask

  task automatic t_prst();
    logic [31:0] v;
    wr(8'h14, 32'h0000_00F5);
    chk("R8 periphRst", 32'(periphRst), 32'h5);
    rd(8'h14, v); chk("R8 readback", v, 32'h5);
    wr(8'h14, 32'h0000_000A);
    chk("R8 periphRst swap", 32'(periphRst), 32'hA);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h18, 32'h0000_00FF);
    rd(8'h18, v); chk("R10 mask keeps 7:2", v, 32'hFC);
    wr(8'h18, 32'h0000_000C);
    @(negedge clk); irqSrc = 6'b000100;
    @(negedge clk);
    chk("R10 unmasked source quiet", 32'(irqOut), 0);
    rd(8'h1C, v); chk("R9 pending bit4", v, 32'h10);
    irqSrc = 6'b000010;
    @(negedge clk);
    chk("R10 enabled source raises", 32'(irqOut), 1);
    wr(8'h1C, 32'h0000_0000);
    rd(8'h1C, v); chk("R9 status write ignored", v, 32'h08);
    irqSrc = '0;
    @(negedge clk);
    chk("R10 source gone", 32'(irqOut), 0);
  endtask

  task automatic t_bridge();
    chk("R11 forced", bridgeAddrOut, 32'h1BCD_1234);
    wr(8'h20, 32'h0000_0000);
    chk("R11 pass through", bridgeAddrOut, 32'hABCD_1234);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'h24, v); chk("R12 unmapped", v, 0);
    rd(8'h09, v); chk("R12 misaligned", v, 0);
    rd(8'h10, v); chk("R12 swr reads zero", v, 0);
  endtask

  task automatic t_swrst_bad();
    wr(8'h08, 32'h1);
    wr(8'h10, 32'h0001_DEAD);
    chk("R6 upper bits block reset", 32'(boardRst), 0);
    wr(8'h10, 32'h0000_BEEF);
    @(negedge clk);
    chk("R6 wrong value no reset", 32'(boardRst), 0);
    chk("R6 led untouched", 32'(ledOn), 1);
  endtask

  task automatic t_swrst_good();
    logic [31:0] v;
    int n;
    wr(8'h0C, 32'h0);
    wr(8'h14, 32'hF);
    wr(8'h18, 32'hFC);
    irqSrc = 6'h3F;
    wr(8'h10, 32'h0000_DEAD);
    chk("R7 flashWp in pulse", 32'(flashWp), 1);
    chk("R7 periphRst in pulse", 32'(periphRst), 0);
    n = 0;
    while (boardRst === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R6 pulse length", 32'(n), 16);
    rd(8'h0C, v); chk("R7 wp restored", v, 32'hFF);
    rd(8'h18, v); chk("R7 mask restored", v, 0);
    rd(8'h20, v); chk("R7 cfg restored", v, 1);
    chk("R7 led restored", 32'(ledOn), 0);
    irqSrc = '0;
    wr(8'h10, 32'h0000_DEAD);
    wr(8'h08, 32'h1);
    n = 0;
    while (boardRst === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R7 write in pulse ignored", 32'(ledOn), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_date();
    t_status();
    t_led();
    t_wp();
    t_prst();
    t_irq();
    t_bridge();
    t_unmapped();
    t_swrst_bad();
    t_swrst_good();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule